// File: doc/BRIEF.md
# Frame Buffer Scan Sequencer

This block reads a packed display image out of shared main memory, one 32-bit word at a time, and marks where each pixel row and each frame begins and ends. It is meant for a single-panel multiplexed LCD path. The fetched words go straight to a downstream pixel unpacker. Software supplies a base word address, the row width as a code in 16-pixel blocks, a colour depth of 1, 2 or 4 bits per pixel, and the image size in 32-bit words. The block never takes a row count. It works out where the rows fall by walking the bit stream.

The memory port is a plain request/grant pair, because the processor uses the same bus. While the sequencer is fetching, it holds its request and address steady until a grant arrives. Read data is taken in the cycle of the grant. One cycle later, each granted word comes out with a valid strobe, together with a line marker when the word completes a row and a frame marker when it is the first word of a frame.

At the end of the last whole row, the address returns to the base address. A configuration loaded from the inputs at that same moment governs the next frame. Rows may straddle word boundaries. A trailing fraction of a row in the buffer is never fetched.

Top module: `fbs_scan_sequencer`

## Requirements
- R1: The row width in bits is 16 × (L + 1) × B. L is the length code, and code 0 is treated as code 1 (32 pixels). B is the depth: select 0 gives 1 bit, select 1 gives 2 bits, and selects 2 and 3 both give 4 bits.
- R2: While running, mem_req stays high. mem_addr holds its value until mem_gnt is seen high with mem_req, and then advances by exactly one word.
- R3: A frame covers R = floor(size × 32 / row bits) whole rows, which is ceil(R × row bits / 32) words. After the last of these words is granted, mem_addr returns to the base address, wrapping modulo 2^ADDR_W on the way.
- R4: line_pulse is high for one cycle, together with pix_valid, for exactly those words that contain the final bit of a row.
- R5: frame_pulse is high for one cycle, together with pix_valid, for the first word of every frame.
- R6: pix_valid is high in the cycle after each grant and at no other time, and pix_data then equals the mem_rdata seen with that grant.
- R7: The inputs are sampled only when fetching starts from idle and in the cycle of the last grant of a frame. Changing them mid-frame does not change the frame in progress.
- R8: No request is made when the enable is low or when the buffer holds less than one whole row. Clearing the enable mid-frame stops requests after that frame's last word.
- R9: After reset, mem_req, pix_valid, line_pulse and frame_pulse are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Scanning enable |
| cfg_base | input | ADDR_W | Base word address of the image |
| cfg_len_code | input | LEN_W | Row width in 16-pixel blocks, minus one |
| cfg_bpp_sel | input | 2 | Colour depth select |
| cfg_size_words | input | SIZE_W | Image size in 32-bit words |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_gnt | input | 1 | Grant; mem_rdata valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| pix_valid | output | 1 | Fetched word valid |
| pix_data | output | DATA_W | Fetched word to the unpacker |
| line_pulse | output | 1 | Word completes a row |
| frame_pulse | output | 1 | First word of a frame |

## Verification
The bench builds the block with ADDR_W set to 12. This lets a frame placed near the top of the address space carry the fetch address through its modulo wrap within a few cycles. The other parameters keep their defaults, so the full 6-bit length code and the full 15-bit size field are used. This covers rows of 640 pixels at 4 bits and rows of 48 pixels at 1 bit that straddle word boundaries. Grants arrive in three fixed patterns, so the request hold is exercised under stalls of different lengths.

// File: rtl/fbs_pkg.sv
// Shared definitions for the frame buffer scan sequencer.
// Assumes the colour depth select is a 2-bit code.
package fbs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scan_state_e;

    // Decode the depth select into bits per pixel (2 and 3 both mean 4).
    function automatic logic [2:0] bpp_bits(input logic [1:0] sel);
        logic [2:0] r;
        case (sel)
            2'd0:    r = 3'd1;
            2'd1:    r = 3'd2;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbs_cfg_shadow.sv
// Configuration decode and frame shadow.
// Computes the row width in 16-bit units and the buffer size in 16-bit
// units from the live inputs, and holds the base address and row width
// for the frame in progress. Assumes load_i is raised only at a frame start.
module fbs_cfg_shadow #(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 6,
    parameter int SIZE_W = 15,
    localparam int HALF_W = LEN_W + 3,
    localparam int REM_W  = SIZE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        bpp_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              live_ok_o,
    output logic [REM_W-1:0]  sizeh_live_o,
    output logic [ADDR_W-1:0] base_q_o,
    output logic [HALF_W-1:0] rowh_q_o
);
    logic [LEN_W:0]    blocks;
    logic [HALF_W-1:0] rowh_live;

    // Row width in halfwords = blocks of 16 pixels times bits per pixel.
    always_comb begin
        if (len_i == '0) blocks = (LEN_W+1)'(2);
        else             blocks = {1'b0, len_i} + (LEN_W+1)'(1);
        rowh_live    = HALF_W'(blocks) * HALF_W'(fbs_pkg::bpp_bits(bpp_i));
        sizeh_live_o = {size_i, 1'b0};
        live_ok_o    = en_i && (sizeh_live_o >= REM_W'(rowh_live));
    end

    // Capture the configuration for the coming frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q_o <= '0;
            rowh_q_o <= HALF_W'(2);
        end else if (load_i) begin
            base_q_o <= base_i;
            rowh_q_o <= rowh_live;
        end
    end
endmodule

// File: rtl/fbs_row_tracker.sv
// Row and frame tracker.
// Counts 16-bit units consumed in the current row and units left in the
// buffer, and flags the word that ends a row and the word that ends the
// last whole row of the frame. Assumes a row is at least two units wide.
module fbs_row_tracker #(
    parameter int HALF_W = 9,
    parameter int REM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [REM_W-1:0]  sizeh_i,
    input  logic [HALF_W-1:0] rowh_i,
    output logic              row_end_o,
    output logic              frame_end_o
);
    logic [HALF_W-1:0] pos_q;
    logic [REM_W-1:0]  rem_q;
    logic [HALF_W:0]   sum;
    logic [REM_W-1:0]  rem_after;

    // Decide whether the word being granted closes a row or the frame.
    always_comb begin
        sum         = {1'b0, pos_q} + (HALF_W+1)'(2);
        row_end_o   = sum >= {1'b0, rowh_i};
        rem_after   = rem_q - REM_W'(rowh_i);
        frame_end_o = row_end_o && (rem_after < REM_W'(rowh_i));
    end

    // Advance the row position and remaining size on each granted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            rem_q <= '0;
        end else if (load_i) begin
            pos_q <= '0;
            rem_q <= sizeh_i;
        end else if (step_i) begin
            if (row_end_o) begin
                pos_q <= HALF_W'(sum - {1'b0, rowh_i});
                rem_q <= rem_after;
            end else begin
                pos_q <= HALF_W'(sum);
            end
        end
    end
endmodule

// File: rtl/fbs_addr_gen.sv
// Fetch address generator.
// Holds the current word address and a first-word-of-frame flag; loads
// the base at each frame start and steps one word per grant.
module fbs_addr_gen #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              first_o
);
    // Address counter with modulo wrap and frame-start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            first_o <= 1'b0;
        end else if (load_i) begin
            addr_o  <= base_i;
            first_o <= 1'b1;
        end else if (step_i) begin
            addr_o  <= addr_o + ADDR_W'(1);
            first_o <= 1'b0;
        end
    end
endmodule

// File: rtl/fbs_out_stage.sv
// Output register toward the pixel unpacker.
// Registers the granted word and its row and frame markers.
module fbs_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              line_i,
    input  logic              frame_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              line_o,
    output logic              frame_o
);
    // Register strobes every cycle; data only on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            line_o  <= 1'b0;
            frame_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= take_i;
            line_o  <= take_i && line_i;
            frame_o <= take_i && frame_i;
            if (take_i) data_o <= data_i;
        end
    end
endmodule

// File: rtl/fbs_scan_sequencer.sv
// Frame buffer scan sequencer, top level.
// Fetches a packed image from shared memory over a request/grant port and
// marks row and frame boundaries. Assumes mem_rdata is valid in the cycle
// mem_gnt is high, and that configuration is sampled only at frame starts.
module fbs_scan_sequencer #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6,
    parameter int SIZE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len_code,
    input  logic [1:0]        cfg_bpp_sel,
    input  logic [SIZE_W-1:0] cfg_size_words,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic              line_pulse,
    output logic              frame_pulse
);
    import fbs_pkg::*;

    localparam int HALF_W = LEN_W + 3;
    localparam int REM_W  = SIZE_W + 1;

    scan_state_e       state_q;
    logic              live_ok;
    logic [REM_W-1:0]  sizeh_live;
    logic [ADDR_W-1:0] base_q;
    logic [HALF_W-1:0] rowh_q;
    logic              take;
    logic              row_end;
    logic              frame_end;
    logic              frame_wrap;
    logic              cfg_load;
    logic              first_word;

    // Strobes for a granted word, a frame wrap and a configuration load.
    always_comb begin
        take       = (state_q == ST_RUN) && mem_gnt;
        frame_wrap = take && frame_end;
        cfg_load   = ((state_q == ST_IDLE) && live_ok) || frame_wrap;
        mem_req    = (state_q == ST_RUN);
    end

    // Run/idle control: start on a valid setup, re-check at every wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 state_q <= ST_IDLE;
        else if (state_q == ST_IDLE && live_ok)     state_q <= ST_RUN;
        else if (frame_wrap)                        state_q <= live_ok ? ST_RUN : ST_IDLE;
    end

    fbs_cfg_shadow #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .en_i(cfg_enable),
        .base_i(cfg_base), .len_i(cfg_len_code), .bpp_i(cfg_bpp_sel),
        .size_i(cfg_size_words), .live_ok_o(live_ok), .sizeh_live_o(sizeh_live),
        .base_q_o(base_q), .rowh_q_o(rowh_q)
    );

    fbs_row_tracker #(.HALF_W(HALF_W), .REM_W(REM_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .step_i(take),
        .sizeh_i(sizeh_live), .rowh_i(rowh_q),
        .row_end_o(row_end), .frame_end_o(frame_end)
    );

    fbs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .step_i(take),
        .base_i(cfg_base), .addr_o(mem_addr), .first_o(first_word)
    );

    fbs_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .take_i(take), .data_i(mem_rdata),
        .line_i(row_end), .frame_i(first_word),
        .valid_o(pix_valid), .data_o(pix_data),
        .line_o(line_pulse), .frame_o(frame_pulse)
    );
endmodule

// File: rtl/fbs_scan_checker.sv
// Protocol checker for the scan sequencer, attached by bind.
module fbs_scan_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pix_valid,
    input logic              line_pulse,
    input logic              frame_pulse,
    input logic              wrap_i,
    input logic [ADDR_W-1:0] base_i
);
    a_r2_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r2_step_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !wrap_i) |=> (mem_addr == $past(mem_addr) + 1'b1));

    a_r3_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && wrap_i) |=> (mem_addr == base_i));

    a_r6_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> pix_valid);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_gnt) |=> !pix_valid);

    a_r4_line_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |-> pix_valid);

    a_r5_frame_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> pix_valid);
endmodule

bind fbs_scan_sequencer fbs_scan_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .pix_valid(pix_valid), .line_pulse(line_pulse),
    .frame_pulse(frame_pulse), .wrap_i(frame_wrap), .base_i(base_q)
);

// File: tb/test_fbs_scan_sequencer.sv
module test_fbs_scan_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_enable = 1'b0;
    logic [AW-1:0]   cfg_base = '0;
    logic [5:0]      cfg_len_code = '0;
    logic [1:0]      cfg_bpp_sel = '0;
    logic [14:0]     cfg_size_words = '0;
    logic            mem_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_gnt = 1'b0;
    logic [31:0]     mem_rdata = '0;
    logic            pix_valid;
    logic [31:0]     pix_data;
    logic            line_pulse;
    logic            frame_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int m_rowbits, m_rows, m_words, m_base, m_k;
    bit m_run;
    bit pv_exp, pl_exp, pf_exp;
    logic [31:0] pd_exp;
    int grants;
    int chg_at;
    bit chg_en; int chg_base, chg_code, chg_bpp, chg_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbs_scan_sequencer #(.ADDR_W(AW)) i_fbs_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
        .cfg_len_code(cfg_len_code), .cfg_bpp_sel(cfg_bpp_sel),
        .cfg_size_words(cfg_size_words), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
        .pix_data(pix_data), .line_pulse(line_pulse), .frame_pulse(frame_pulse)
    );

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Watchdog: an overlong run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Load the reference frame geometry from the driven inputs (R1, R3).
    task automatic load_model();
        int n, b;
        n = ((cfg_len_code == 0) ? 1 : int'(cfg_len_code)) + 1;
        b = (cfg_bpp_sel == 0) ? 1 : (cfg_bpp_sel == 1) ? 2 : 4;
        m_rowbits = n * 16 * b;
        m_rows    = int'(cfg_size_words) * 32 / m_rowbits;
        m_words   = (m_rows * m_rowbits + 31) / 32;
        m_base    = int'(cfg_base);
        m_k       = 0;
        m_run     = cfg_enable && (m_rows > 0);
    endtask

    task automatic do_reset();
        mem_gnt = 1'b0;
        cfg_enable = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_case(string tag, int base, int code, int bpp, int size,
                            int ncyc, int gmode);
        bit g;
        int lo, hi;
        do_reset();
        cfg_base = AW'(base); cfg_len_code = 6'(code);
        cfg_bpp_sel = 2'(bpp); cfg_size_words = 15'(size); cfg_enable = 1'b1;
        load_model();
        pv_exp = 0; pl_exp = 0; pf_exp = 0; pd_exp = '0; grants = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            cyc++;
            chk(pix_valid == pv_exp, {tag, " R6 valid"}, pix_valid, pv_exp);
            chk(line_pulse == pl_exp, {tag, " R4 line"}, line_pulse, pl_exp);
            chk(frame_pulse == pf_exp, {tag, " R5 frame"}, frame_pulse, pf_exp);
            if (pv_exp) chk(pix_data == pd_exp, {tag, " R6 data"}, pix_data, pd_exp);
            chk(mem_req == m_run, {tag, " R2/R8 req"}, mem_req, m_run);
            if (chg_at >= 0 && grants == chg_at) begin
                cfg_enable = chg_en; cfg_base = AW'(chg_base);
                cfg_len_code = 6'(chg_code); cfg_bpp_sel = 2'(chg_bpp);
                cfg_size_words = 15'(chg_size);
                chg_at = -1;
            end
            g = 0;
            if (mem_req && m_run) begin
                chk(int'(mem_addr) == ((m_base + m_k) % (1 << AW)), {tag, " R3 addr"},
                    mem_addr, (m_base + m_k) % (1 << AW));
                case (gmode)
                    0: g = 1;
                    1: g = (cyc % 2) == 0;
                    default: g = (cyc % 3) != 0;
                endcase
            end
            mem_gnt = g;
            pv_exp = g; pl_exp = 0; pf_exp = 0;
            if (g) begin
                mem_rdata = {8'hC3, 12'(cyc), mem_addr};
                pd_exp = {8'hC3, 12'(cyc), mem_addr};
                lo = 32 * m_k; hi = lo + 32;
                pl_exp = (hi / m_rowbits) > (lo / m_rowbits);
                pf_exp = (m_k == 0);
                grants++;
                m_k++;
                if (m_k == m_words) load_model();
            end
        end
        @(negedge clk);
        mem_gnt = 1'b0;
    endtask

    // R9: idle outputs after reset.
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(mem_req == 0, "R9 req", mem_req, 0);
        chk(pix_valid == 0, "R9 valid", pix_valid, 0);
        chk(line_pulse == 0, "R9 line", line_pulse, 0);
        chk(frame_pulse == 0, "R9 frame", frame_pulse, 0);
    endtask

    initial begin
        chg_at = -1;
        t_reset();
        // R4 R5: one word per row, back-to-back grants, several frames
        run_case("basic", 100, 1, 0, 8, 40, 0);
        // R1 R4: 48-pixel rows at 1 bit straddle words; partial row dropped (R3)
        run_case("straddle", 20, 2, 0, 10, 60, 1);
        // R1: 640 pixels at 4 bits, 80 words per row, stalled grants
        run_case("wide4bpp", 500, 39, 2, 500, 1000, 2);
        // R1: length code 0 behaves as 32 pixels
        run_case("code0", 7, 0, 1, 6, 30, 0);
        // R1: depth select 3 behaves as 4 bits
        run_case("bpp3", 9, 3, 3, 17, 50, 2);
        // R3: address wraps modulo the address space
        run_case("addrwrap", 4090, 1, 1, 10, 40, 1);
        // R8: buffer smaller than one row never requests
        run_case("toosmall", 0, 3, 2, 7, 30, 0);
        // R7: mid-frame change only takes effect at the frame boundary
        chg_at = 2; chg_en = 1; chg_base = 300; chg_code = 1; chg_bpp = 1; chg_size = 6;
        run_case("midchange R7", 200, 1, 0, 4, 40, 0);
        // R8: clearing the enable stops after the frame in progress
        chg_at = 2; chg_en = 0; chg_base = 50; chg_code = 1; chg_bpp = 0; chg_size = 5;
        run_case("stop R8", 50, 1, 0, 5, 30, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule